// File: doc/BRIEF.md
# Fractional-Duty PWM Generator with Pulse Insertion

This block produces a free-running pulse-width-modulated output from an 8-bit period counter. The duty setting has four extra fraction bits. Over a frame of 16 consecutive PWM periods, the fraction bits choose which periods get their active phase shortened by one counter step. In those periods the switch to the active level happens one count later. The average duty therefore resolves to 1/16 of a count, and every period still has the same length.

Software-facing registers sit outside this block. It takes a run request, a count-enable tick from an external prescaler, a duty value, a fraction value and an idle-level select. The duty and fraction values are captured at the start of each period, so a write during a period never produces a torn pulse. The idle level is captured when the generator starts. While the generator is stopped, the pin follows the idle-level select directly.

Top module: `pwm_insert_gen`

## Requirements
- R1: After reset, `ovf_o` is 0, the generator is stopped, and `pwm_o` equals `init_lvl_i`.
- R2: While stopped, `pwm_o` equals `init_lvl_i` in every cycle, including cycles in which that input changes.
- R3: While running, `pwm_o` is at the captured idle level when the count is below the threshold. From the count equal to the threshold up to 255 it is at the opposite level. The threshold is the captured duty value, plus 1 in a period that receives an insertion.
- R4: When the count wraps from 255 to 0, `pwm_o` returns to the captured idle level, unless the new period's threshold is 0.
- R5: `ovf_o` is high for exactly one clock: the cycle in which the count has just wrapped to 0. It is low at every other time.
- R6: Periods are numbered 1 to 16 within a frame. Fraction bit 3 inserts in the even periods. Bit 2 inserts in periods 3, 7, 11 and 15. Bit 1 inserts in periods 5 and 13. Bit 0 inserts in period 9. Period 1 never receives an insertion.
- R7: Starting sets the period number to 1. Each wrap advances it, and it goes from 16 back to 1. Over one frame at constant settings with duty D and fraction F, the output spends 16·(256−D)−F counted cycles at the opposite level, and `ovf_o` pulses 15 times within the frame.
- R8: A change of `duty_i` or `frac_i` while running has no effect until the next wrap.
- R9: A change of `init_lvl_i` while running has no effect until the generator is stopped and restarted.
- R10: When `cnt_en_i` is low, the count and `pwm_o` hold.
- R11: With duty 0 and no insertion, `pwm_o` is at the opposite level for the whole period.
- R12: The first clock edge that sees `run_i` high starts the generator at count 0. Counting begins on the following edge. Dropping `run_i` stops the generator on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Run request; low stops and rearms the generator |
| cnt_en_i | input | 1 | Count-enable tick from an external prescaler |
| duty_i | input | 8 | Duty threshold, captured at start and at each wrap |
| frac_i | input | 4 | Fraction bits selecting insertion periods |
| init_lvl_i | input | 1 | Idle level: 0 low, 1 high |
| pwm_o | output | 1 | PWM output |
| ovf_o | output | 1 | One-clock pulse at each wrap to count 0 |

## Verification
All state sits one register stage from its inputs, and `pwm_o` decodes that state with no further register. A change at the inputs therefore shows on the pins after the next rising edge. The one exception is the stopped state, where `pwm_o` follows `init_lvl_i` at once. The bench drives the inputs on the falling edge and advances its reference model on the rising edge that consumes them. It compares the pins at the next falling edge, before new inputs go out, so each result is sampled in the cycle it is due. The frame-total checks count a 4096-cycle window that starts on the falling edge after the start edge.

// File: rtl/pwm_ins_pkg.sv
package pwm_ins_pkg;
    // default counter width and fraction width
    localparam int CNT_W_DEF  = 8;
    localparam int FRAC_W_DEF = 4;

    // encoding of the captured idle level
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;
endpackage

// File: rtl/pwm_ins_sched.sv
// Decides whether the current period of the frame receives an extra count.
// Fraction bit b fires on periods whose zero-based index has its lowest set bit
// at position FRAC_W-1-b, giving a bit-reversed spread across the frame.
module pwm_ins_sched #(
    parameter int FRAC_W = pwm_ins_pkg::FRAC_W_DEF
) (
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [FRAC_W-1:0] frame_i,
    output logic              ins_o
);
    logic [FRAC_W-1:0] hit;

    for (genvar b = 0; b < FRAC_W; b++) begin : g_bit
        localparam int LSB_POS = FRAC_W - 1 - b;
        localparam logic [FRAC_W-1:0] LOW_MASK = FRAC_W'((1 << LSB_POS) - 1);
        assign hit[b] = frac_i[b] & frame_i[LSB_POS] & ((frame_i & LOW_MASK) == '0);
    end

    assign ins_o = |hit;
endmodule

// File: rtl/pwm_level_cmp.sv
// Threshold compare and output level selection.
module pwm_level_cmp #(
    parameter int CNT_W = pwm_ins_pkg::CNT_W_DEF
) (
    input  logic             run_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic             ins_i,
    input  logic             init_i,
    input  logic             idle_lvl_i,
    output logic             pwm_o
);
    logic [CNT_W:0] thr;
    logic           active;

    always_comb begin
        thr    = {1'b0, duty_i} + {{CNT_W{1'b0}}, ins_i};
        active = ({1'b0, cnt_i} >= thr);
        pwm_o  = run_i ? (init_i ^ active) : idle_lvl_i;
    end
endmodule

// File: rtl/pwm_insert_gen.sv
module pwm_insert_gen #(
    parameter int CNT_W  = pwm_ins_pkg::CNT_W_DEF,
    parameter int FRAC_W = pwm_ins_pkg::FRAC_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              cnt_en_i,
    input  logic [CNT_W-1:0]  duty_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              init_lvl_i,
    output logic              pwm_o,
    output logic              ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic               run;
        logic [CNT_W-1:0]   cnt;
        logic [FRAC_W-1:0]  frame;   // period number minus one
        logic [CNT_W-1:0]   duty;
        logic [FRAC_W-1:0]  frac;
        pwm_ins_pkg::lvl_e  init;
        logic               ovf;
    } state_t;

    state_t st_d, st_q;
    logic   tick;
    logic   wrap;
    logic   ins;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        tick     = st_q.run & run_i & cnt_en_i;
        wrap     = tick & (st_q.cnt == CNT_MAX);
        if (!st_q.run) begin
            // stopped: rearm and keep sampling the settings
            st_d.cnt   = '0;
            st_d.frame = '0;
            st_d.duty  = duty_i;
            st_d.frac  = frac_i;
            st_d.init  = pwm_ins_pkg::lvl_e'(init_lvl_i);
            st_d.run   = run_i;
        end else if (!run_i) begin
            st_d.run = 1'b0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (wrap) begin
                st_d.frame = st_q.frame + 1'b1;
                st_d.duty  = duty_i;
                st_d.frac  = frac_i;
                st_d.ovf   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    pwm_ins_sched #(
        .FRAC_W (FRAC_W)
    ) i_sched (
        .frac_i  (st_q.frac),
        .frame_i (st_q.frame),
        .ins_o   (ins)
    );

    pwm_level_cmp #(
        .CNT_W (CNT_W)
    ) i_cmp (
        .run_i      (st_q.run),
        .cnt_i      (st_q.cnt),
        .duty_i     (st_q.duty),
        .ins_i      (ins),
        .init_i     (st_q.init),
        .idle_lvl_i (init_lvl_i),
        .pwm_o      (pwm_o)
    );

    assign ovf_o = st_q.ovf;
endmodule

// File: rtl/pwm_insert_gen_chk.sv
module pwm_insert_gen_chk #(
    parameter int CNT_W  = pwm_ins_pkg::CNT_W_DEF,
    parameter int FRAC_W = pwm_ins_pkg::FRAC_W_DEF
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cnt_en_i,
    input logic              init_lvl_i,
    input logic              pwm_o,
    input logic              ovf_o,
    input logic              run_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  duty_q,
    input logic [FRAC_W-1:0] frac_q,
    input logic              init_q
);
    logic [CNT_W:0] duty_p1;
    assign duty_p1 = {1'b0, duty_q} + {{CNT_W{1'b0}}, 1'b1};

    p_stop_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_q |-> pwm_o == init_lvl_i);

    p_ovf_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |=> !ovf_o);

    p_ovf_at_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> (run_q && cnt_q == '0));

    p_shadow_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && $past(run_q) && !ovf_o) |-> ($stable(duty_q) && $stable(frac_q)));

    p_init_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && $past(run_q)) |-> $stable(init_q));

    p_edge_at_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && $past(run_q) && pwm_o != $past(pwm_o))
        |-> (ovf_o || cnt_q == duty_q || {1'b0, cnt_q} == duty_p1));

    p_en_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && $past(run_q) && !$past(cnt_en_i)) |-> ($stable(pwm_o) && $stable(cnt_q)));
endmodule

bind pwm_insert_gen pwm_insert_gen_chk #(
    .CNT_W  (CNT_W),
    .FRAC_W (FRAC_W)
) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_en_i   (cnt_en_i),
    .init_lvl_i (init_lvl_i),
    .pwm_o      (pwm_o),
    .ovf_o      (ovf_o),
    .run_q      (st_q.run),
    .cnt_q      (st_q.cnt),
    .duty_q     (st_q.duty),
    .frac_q     (st_q.frac),
    .init_q     (st_q.init)
);

// File: tb/test_pwm_insert_gen.sv
module test_pwm_insert_gen;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       run_i = 1'b0;
    logic       cnt_en_i = 1'b0;
    logic [7:0] duty_i = '0;
    logic [3:0] frac_i = '0;
    logic       init_lvl_i = 1'b0;
    logic       pwm_o;
    logic       ovf_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    bit m_run = 0;
    int m_cnt = 0;
    int m_frame = 1;
    int m_duty = 0;
    int m_frac = 0;
    bit m_init = 0;
    bit m_ovf = 0;

    always #4 clk_i = ~clk_i;

    pwm_insert_gen i_pwm_insert_gen (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run_i),
        .cnt_en_i   (cnt_en_i),
        .duty_i     (duty_i),
        .frac_i     (frac_i),
        .init_lvl_i (init_lvl_i),
        .pwm_o      (pwm_o),
        .ovf_o      (ovf_o)
    );

    // insertion schedule taken from R6, by period number 1..16
    function automatic int ins_of(input int f, input int p);
        bit hit = 0;
        if (f[3] && (p % 2 == 0)) hit = 1;
        if (f[2] && (p == 3 || p == 7 || p == 11 || p == 15)) hit = 1;
        if (f[1] && (p == 5 || p == 13)) hit = 1;
        if (f[0] && p == 9) hit = 1;
        return hit ? 1 : 0;
    endfunction

    function automatic bit exp_pwm();
        if (!m_run) return init_lvl_i;
        return m_init ^ (m_cnt >= m_duty + ins_of(m_frac, m_frame));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cnt %0d period %0d)",
                     tag, act, exp, m_cnt, m_frame);
        end
    endtask

    task automatic check_pins();
        string tag;
        if (!m_run) tag = "R2";
        else if (ins_of(m_frac, m_frame) != 0) tag = "R6";
        else if (m_duty == 0 && m_frac == 0) tag = "R11";
        else if (duty_i != m_duty || frac_i != m_frac) tag = "R8";
        else if (init_lvl_i != m_init) tag = "R9";
        else if (!cnt_en_i) tag = "R10";
        else if (m_cnt == 0) tag = "R4";
        else tag = "R3";
        chk(tag, pwm_o, exp_pwm());
        chk("R5", ovf_o, m_ovf);
    endtask

    // called just after a rising edge: advance the model with the inputs it saw
    task automatic model_edge();
        bit nx_ovf;
        nx_ovf = m_run && run_i && cnt_en_i && m_cnt == 255;
        if (!m_run) begin
            m_cnt = 0; m_frame = 1;             // R7, R12
            m_duty = duty_i; m_frac = frac_i; m_init = init_lvl_i;
            m_run = run_i;
        end else if (!run_i) begin
            m_run = 0;
        end else if (cnt_en_i) begin
            if (m_cnt == 255) begin
                m_cnt = 0;
                m_frame = (m_frame == 16) ? 1 : m_frame + 1;
                m_duty = duty_i; m_frac = frac_i;
            end else begin
                m_cnt++;
            end
        end
        m_ovf = nx_ovf;
    endtask

    // at a falling edge: check, drive, take one rising edge, return at the next falling edge
    task automatic step(input bit r, input bit en, input int d, input int f, input bit il);
        check_pins();
        run_i = r; cnt_en_i = en; duty_i = 8'(d); frac_i = 4'(f); init_lvl_i = il;
        @(posedge clk_i);
        model_edge();
        @(negedge clk_i);
    endtask

    // one whole frame at constant settings, counted at the pins (R7)
    task automatic frame_sum(input int d, input int f, input bit il);
        int opp = 0;
        int ovc = 0;
        step(0, 1, d, f, il);
        step(0, 1, d, f, il);
        step(1, 1, d, f, il);               // start edge (R12)
        chk("R12", m_cnt, 0);
        for (int i = 0; i < 4096; i++) begin
            if (pwm_o != il) opp++;
            if (ovf_o) ovc++;
            step(1, 1, d, f, il);
        end
        chk("R7", opp, 16 * (256 - d) - f);
        chk("R7", ovc, 15);
    endtask

    initial begin
        repeat (250000) @(posedge clk_i);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        @(negedge clk_i);
        init_lvl_i = 1'b1;
        #1;
        chk("R1", pwm_o, 1);
        chk("R1", ovf_o, 0);
        init_lvl_i = 1'b0;
        #1;
        chk("R1", pwm_o, 0);
        @(negedge clk_i);
        rst_ni = 1'b1;

        // stopped: output tracks select (R2)
        for (int i = 0; i < 8; i++) step(0, 1, 50, 3, i[0]);

        // duty 0, no insertion: opposite the whole period (R11)
        step(1, 1, 0, 0, 0);
        for (int i = 0; i < 600; i++) step(1, 1, 0, 0, 0);
        step(0, 1, 0, 0, 0);

        // frame totals, including insertion past the last count (R7, R6)
        frame_sum(100, 11, 1);
        frame_sum(255, 8, 0);
        frame_sum(0, 15, 1);
        frame_sum(254, 15, 0);

        // count enable held low mid-period (R10)
        step(0, 1, 40, 0, 0);
        step(1, 1, 40, 0, 0);
        for (int i = 0; i < 45; i++) step(1, 1, 40, 0, 0);
        for (int i = 0; i < 20; i++) step(1, 0, 40, 0, 0);
        chk("R10", m_cnt, 45);
        for (int i = 0; i < 300; i++) step(1, 1, 40, 0, 0);
        step(0, 1, 40, 0, 0);

        // constrained random segments
        for (int s = 0; s < 24; s++) begin
            int d, f, len;
            bit il;
            int pick;
            pick = $urandom_range(0, 9);
            d = (pick == 0) ? 0 : (pick == 1) ? 255 : (pick == 2) ? 254 : (pick == 3) ? 1 : $urandom_range(0, 255);
            f = $urandom_range(0, 15);
            il = 1'($urandom_range(0, 1));
            len = $urandom_range(1500, 2500);
            for (int c = 0; c < len; c++) begin
                bit r, en;
                r = ($urandom_range(0, 999) != 0);
                en = ($urandom_range(0, 7) != 0);
                if ($urandom_range(0, 299) == 0) d = $urandom_range(0, 255);
                if ($urandom_range(0, 299) == 0) f = $urandom_range(0, 15);
                if ($urandom_range(0, 399) == 0) il = ~il;
                step(r, en, d, f, il);
            end
        end

        check_pins();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule